// File: doc/BRIEF.md
# Downward Word-Aligned Hardware Stack

This block keeps a last-in, first-out stack in a small word-wide RAM. A byte-address stack pointer selects the slot. The stack grows toward lower addresses. The pointer always holds the address of the item pushed most recently, so it is also the address the next pop will read. The pointer moves in steps of two bytes and is never odd. Two parameters set its limits. `TOP_ADDR` is the value after reset and the empty position. `BOT_ADDR` is the lowest address that may hold an item.

A client drives one request per cycle:

- **Push.** Carries write data and a byte/word flag.
- **Pop.** Returns the stored word on the next cycle, with a valid strobe.
- **Direct pointer load.** Replaces the pointer. An illegal value raises an error strobe.

Pushes beyond the floor and pops from an empty stack are refused and flagged. The pointer does not move in either case. A cycle that asks for both a push and a pop does nothing.

All results appear one cycle after the request: the pointer, the popped data and strobe, and the flags. A popped word stays in the RAM, but the moved pointer means no later pop returns it until it is pushed again.

Top module: `hws_stack`

## Requirements
- R1: During and after reset the pointer equals `TOP_ADDR` (0x40 by default), and the overflow, underflow, load-error and pop-valid outputs are 0.
- R2: An accepted push lowers the pointer by 2 on the next cycle and stores the data at the new pointer address.
- R3: An accepted pop returns, one cycle later, the word at the current pointer address with `pop_valid_o` high, and raises the pointer by 2.
- R4: Pops return items in reverse push order; once a word has been popped, the next pop returns the word pushed before it, not the same word again.
- R5: A push with `push_byte_i` high stores bits 7:0 of the data; bits 15:8 of that slot are undefined when it is popped.
- R6: A push while the pointer equals `BOT_ADDR` (0x30 by default) is refused: `ovf_o` is 1 for one cycle and the pointer is unchanged.
- R7: A pop while the pointer equals `TOP_ADDR` is refused: `udf_o` is 1 for one cycle, the pointer is unchanged and `pop_valid_o` stays 0.
- R8: A cycle with both push and pop requested (and no load) changes nothing: the pointer holds and no flag or pop-valid is raised.
- R9: A load of a value inside [`BOT_ADDR`, `TOP_ADDR`] sets the pointer to the value with bit 0 cleared; if bit 0 of the value was 1, `load_err_o` is 1 for one cycle.
- R10: A load whose value (bit 0 cleared) lies outside [`BOT_ADDR`, `TOP_ADDR`] raises `load_err_o` and leaves the pointer unchanged.
- R11: A load takes priority: any push or pop requested in the same cycle is ignored.
- R12: The pointer is always even and within [`BOT_ADDR`, `TOP_ADDR`].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| push_byte_i | input | 1 | 1: byte push, 0: word push |
| push_data_i | input | 16 | Data to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 16 | Popped word, valid with pop_valid_o |
| pop_valid_o | output | 1 | Pop accepted in the previous cycle |
| load_i | input | 1 | Direct pointer load request |
| load_val_i | input | 8 | Value for the pointer load |
| load_err_o | output | 1 | Previous load was odd or out of range |
| sp_o | output | 8 | Current stack pointer (byte address) |
| ovf_o | output | 1 | Previous push was refused at the floor |
| udf_o | output | 1 | Previous pop was refused on an empty stack |

## Verification
The bench fills the stack until a push is refused at the floor, then drains it until a pop is refused at the top. A design that compared against the wrong limit would write one slot past the region, or return stale data from above the top.

Other directed cases probe request handling:

- **Push and pop together.** Catches a design that lets one of the two win.
- **Load with a push or pop in the same cycle.** Catches a design that applies both updates.
- **Odd and out-of-range loads.** An odd load must still be accepted with bit 0 cleared. An out-of-range load must be dropped.

Random traffic with byte pushes mixed in tests write-then-step ordering against read-then-step ordering. A design that swapped them would return the neighbouring slot on every pop.

// File: rtl/hws_pkg.sv
package hws_pkg;

  // Request class seen by the pointer logic in one cycle
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLASH = 3'd4
  } hws_op_e;

  // Load wins over everything; push with pop together is a clash
  function automatic hws_op_e classify(input logic push, input logic pop,
                                       input logic load);
    if (load)             return OP_LOAD;
    else if (push && pop) return OP_CLASH;
    else if (push)        return OP_PUSH;
    else if (pop)         return OP_POP;
    else                  return OP_IDLE;
  endfunction

endpackage

// File: rtl/hws_ptr.sv
module hws_ptr #(
  parameter int unsigned AW       = 8,
  parameter int unsigned TOP_ADDR = 'h40,
  parameter int unsigned BOT_ADDR = 'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] wr_addr,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf,
  output logic          udf,
  output logic          lerr
);
  import hws_pkg::*;

  localparam logic [AW-1:0] TOP = AW'(TOP_ADDR);
  localparam logic [AW-1:0] BOT = AW'(BOT_ADDR);

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] a);
    return a - AW'(2);
  endfunction

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] a);
    return a + AW'(2);
  endfunction

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return {a[AW-1:1], 1'b0};
  endfunction

  hws_op_e         op;
  logic            at_floor, at_top, load_in_rng, load_take;
  logic [AW-1:0]   load_even, sp_q, sp_d;

  assign op          = classify(push, pop, load);
  assign at_floor    = (sp_q == BOT);
  assign at_top      = (sp_q == TOP);
  assign load_even   = align(load_val);
  assign load_in_rng = (load_even >= BOT) && (load_even <= TOP);
  assign load_take   = (op == OP_LOAD) && load_in_rng;
  assign push_ok     = (op == OP_PUSH) && !at_floor;
  assign pop_ok      = (op == OP_POP) && !at_top;
  assign wr_addr     = step_down(sp_q);

  always_comb begin
    sp_d = sp_q;
    if (load_take)    sp_d = load_even;
    else if (push_ok) sp_d = step_down(sp_q);
    else if (pop_ok)  sp_d = step_up(sp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= TOP;
      ovf  <= 1'b0;
      udf  <= 1'b0;
      lerr <= 1'b0;
    end else begin
      sp_q <= sp_d;
      ovf  <= (op == OP_PUSH) && at_floor;
      udf  <= (op == OP_POP) && at_top;
      lerr <= (op == OP_LOAD) && (load_val[0] || !load_in_rng);
    end
  end

  assign sp = sp_q;

endmodule

// File: rtl/hws_ram.sv
module hws_ram #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LANES = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          we_byte,
  input  logic [SW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [SW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  // One array per byte lane; lane 0 is written on every push,
  // upper lanes only on word pushes.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic       lane_we;

    if (ln == 0) begin : g_low
      assign lane_we = we;
    end else begin : g_high
      assign lane_we = we && !we_byte;
    end

    always_ff @(posedge clk) begin
      if (lane_we) mem[waddr] <= wdata[ln*8 +: 8];
      if (re)      rdata[ln*8 +: 8] <= mem[raddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end

endmodule

// File: rtl/hws_stack.sv
module hws_stack #(
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 16,
  parameter int unsigned TOP_ADDR = 'h40,
  parameter int unsigned BOT_ADDR = 'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          push_byte_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic          load_err_o,
  output logic [AW-1:0] sp_o,
  output logic          ovf_o,
  output logic          udf_o
);

  localparam int unsigned DEPTH = (TOP_ADDR - BOT_ADDR) / 2;
  localparam int unsigned SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Named internal events, observed by the bound checker
  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_slot, rd_slot;

  function automatic logic [SW-1:0] slot_of(input logic [AW-1:0] a);
    return SW'((a - AW'(BOT_ADDR)) >> 1);
  endfunction

  hws_ptr #(.AW(AW), .TOP_ADDR(TOP_ADDR), .BOT_ADDR(BOT_ADDR)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_i),
    .pop      (pop_i),
    .load     (load_i),
    .load_val (load_val_i),
    .sp       (sp_o),
    .wr_addr  (wr_addr),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .ovf      (ovf_o),
    .udf      (udf_o),
    .lerr     (load_err_o)
  );

  assign wr_slot = slot_of(wr_addr);
  assign rd_slot = slot_of(sp_o);

  hws_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (push_ok),
    .we_byte (push_byte_i),
    .waddr   (wr_slot),
    .wdata   (push_data_i),
    .re      (pop_ok),
    .raddr   (rd_slot),
    .rdata   (pop_data_o),
    .rvalid  (pop_valid_o)
  );

endmodule

// File: rtl/hws_stack_chk.sv
module hws_stack_chk #(
  parameter int unsigned AW       = 8,
  parameter int unsigned TOP_ADDR = 'h40,
  parameter int unsigned BOT_ADDR = 'h30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          load_i,
  input logic [AW-1:0] load_val_i,
  input logic [AW-1:0] sp_o,
  input logic          ovf_o,
  input logic          udf_o,
  input logic          load_err_o,
  input logic          pop_valid_o,
  input logic          push_ok,
  input logic          pop_ok
);
  localparam logic [AW-1:0] TOP = AW'(TOP_ADDR);
  localparam logic [AW-1:0] BOT = AW'(BOT_ADDR);

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp_o == $past(sp_o) - AW'(2));

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (sp_o == $past(sp_o) + AW'(2)) && pop_valid_o);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !load_i && sp_o == BOT) |=> ovf_o && $stable(sp_o));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !load_i && sp_o == TOP) |=> udf_o && $stable(sp_o) && !pop_valid_o);

  p_clash_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !load_i) |=> $stable(sp_o) && !pop_valid_o && !ovf_o && !udf_o);

  p_odd_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i[0]) |=> load_err_o);

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !push_ok && !pop_ok);

  always @(posedge clk) begin
    if (rst_n) begin
      p_sp_legal_r12: assert (sp_o[0] == 1'b0 && sp_o >= BOT && sp_o <= TOP);
    end
  end

endmodule

bind hws_stack hws_stack_chk #(.AW(AW), .TOP_ADDR(TOP_ADDR), .BOT_ADDR(BOT_ADDR)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .load_i      (load_i),
  .load_val_i  (load_val_i),
  .sp_o        (sp_o),
  .ovf_o       (ovf_o),
  .udf_o       (udf_o),
  .load_err_o  (load_err_o),
  .pop_valid_o (pop_valid_o),
  .push_ok     (push_ok),
  .pop_ok      (pop_ok)
);

// File: tb/hws_stack_tb_top.sv
module hws_stack_tb_top;
  localparam int TOP = 'h40;
  localparam int BOT = 'h30;
  localparam int NSLOT = (TOP - BOT) / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, push_byte_i = 1'b0, pop_i = 1'b0, load_i = 1'b0;
  logic [15:0] push_data_i = '0;
  logic [7:0]  load_val_i = '0;
  logic [15:0] pop_data_o;
  logic        pop_valid_o, load_err_o, ovf_o, udf_o;
  logic [7:0]  sp_o;

  int n_chk = 0;
  int n_fail = 0;

  // Reference state
  int          m_sp;
  logic [15:0] m_mem  [NSLOT];
  bit          m_known[NSLOT];
  bit          m_byte [NSLOT];

  always #2 clk = ~clk;

  hws_stack dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_byte_i(push_byte_i),
    .push_data_i(push_data_i), .pop_i(pop_i), .pop_data_o(pop_data_o),
    .pop_valid_o(pop_valid_o), .load_i(load_i), .load_val_i(load_val_i),
    .load_err_o(load_err_o), .sp_o(sp_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  function automatic int slot_at(int a);
    return (a - BOT) / 2;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle of traffic with reference prediction and checks
  task automatic cycle(bit ps, bit pp, bit by, logic [15:0] d, bit ld,
                       logic [7:0] lv, string req);
    int  e_sp, e_v;
    bit  e_ovf, e_udf, e_err, e_val, e_known, e_byte;
    logic [15:0] e_data;
    @(negedge clk);
    push_i = ps; pop_i = pp; push_byte_i = by; push_data_i = d;
    load_i = ld; load_val_i = lv;
    e_sp = m_sp; e_ovf = 0; e_udf = 0; e_err = 0; e_val = 0;
    e_known = 0; e_byte = 0; e_data = '0;
    if (ld) begin
      e_v = int'(lv) & ~1;
      e_err = lv[0] || e_v < BOT || e_v > TOP;
      if (e_v >= BOT && e_v <= TOP) e_sp = e_v;
    end else if (ps && pp) begin
      e_sp = m_sp;
    end else if (ps) begin
      if (m_sp == BOT) e_ovf = 1;
      else begin
        e_sp = m_sp - 2;
        m_mem[slot_at(e_sp)] = d;
        m_known[slot_at(e_sp)] = 1;
        m_byte[slot_at(e_sp)] = by;
      end
    end else if (pp) begin
      if (m_sp == TOP) e_udf = 1;
      else begin
        e_val = 1;
        e_data = m_mem[slot_at(m_sp)];
        e_known = m_known[slot_at(m_sp)];
        e_byte = m_byte[slot_at(m_sp)];
        e_sp = m_sp + 2;
      end
    end
    m_sp = e_sp;
    @(posedge clk);
    #1;
    check(req, "sp", int'(sp_o), e_sp);
    check(req, "ovf", int'(ovf_o), int'(e_ovf));
    check(req, "udf", int'(udf_o), int'(e_udf));
    check(req, "load_err", int'(load_err_o), int'(e_err));
    check(req, "pop_valid", int'(pop_valid_o), int'(e_val));
    if (e_val && e_known) begin
      if (e_byte) check("R5", "pop byte", int'(pop_data_o[7:0]), int'(e_data[7:0]));
      else        check("R4", "pop word", int'(pop_data_o), int'(e_data));
    end
  endtask

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NSLOT; i++) begin
      m_known[i] = 0; m_byte[i] = 0; m_mem[i] = '0;
    end
    m_sp = TOP;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "sp in reset", int'(sp_o), TOP);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "sp after reset", int'(sp_o), TOP);
    check("R1", "flags after reset", int'({ovf_o, udf_o, load_err_o, pop_valid_o}), 0);

    // R7: pop on empty
    cycle(0, 1, 0, 16'h0, 0, 8'h0, "R7");
    // R2 / R4: fill until refusal (R6)
    for (int i = 0; i < NSLOT; i++)
      cycle(1, 0, 0, 16'hA500 + 16'(i), 0, 8'h0, "R2");
    cycle(1, 0, 0, 16'hDEAD, 0, 8'h0, "R6");
    cycle(1, 0, 0, 16'hBEEF, 0, 8'h0, "R6");
    // R8: clash in the middle of a full stack
    cycle(1, 1, 0, 16'h1111, 0, 8'h0, "R8");
    // R3 / R4: drain then R7 again
    for (int i = 0; i < NSLOT; i++)
      cycle(0, 1, 0, 16'h0, 0, 8'h0, "R3");
    cycle(0, 1, 0, 16'h0, 0, 8'h0, "R7");
    // R5: byte push then pop
    cycle(1, 0, 1, 16'h77C3, 0, 8'h0, "R5");
    cycle(0, 1, 0, 16'h0, 0, 8'h0, "R5");
    // R9: odd in-range load, even in-range load
    cycle(0, 0, 0, 16'h0, 1, 8'h39, "R9");
    cycle(0, 0, 0, 16'h0, 1, 8'h34, "R9");
    // R10: out-of-range loads, both sides
    cycle(0, 0, 0, 16'h0, 1, 8'h2E, "R10");
    cycle(0, 0, 0, 16'h0, 1, 8'h42, "R10");
    // R11: load with push, load with pop
    cycle(1, 0, 0, 16'h5A5A, 1, 8'h3C, "R11");
    cycle(0, 1, 0, 16'h0, 1, 8'h40, "R11");

    // Random traffic (R12 covered by sp checks throughout)
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [7:0] lv;
      r = int'($urandom_range(0, 99));
      lv = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                       : 8'($urandom_range(BOT - 2, TOP + 2));
      if (r < 40)      cycle(1, 0, bit'($urandom_range(0, 1)), 16'($urandom), 0, 8'h0, "R2");
      else if (r < 80) cycle(0, 1, 0, 16'h0, 0, 8'h0, "R3");
      else if (r < 86) cycle(1, 1, 0, 16'($urandom), 0, 8'h0, "R8");
      else if (r < 92) cycle(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 0,
                             16'($urandom), 1, lv, "R12");
      else             cycle(0, 0, 0, 16'h0, 0, 8'h0, "R12");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule